// File: doc/BRIEF.md
# Serial Audio Transmit Channel with Word Queue

This block is the transmit side of an I2S audio port in master framing. Words of 32 bits enter an eight-deep queue through a simple write strobe. A serializer takes them out one frame at a time, splits each word into channel samples according to the selected sample width and channel mode, and shifts them out MSB first on a serial data line. A word-select line marks the left channel (low) and the right channel (high). Bit timing comes from a one-cycle enable pulse supplied by an external clock divider, so the whole block runs on the system clock.

Control inputs select the sample width, mono or stereo, muting, the length of each word-select phase, a halt and a clear. The queue occupancy is reported continuously. Three request lines (one interrupt request and two DMA requests) each compare that occupancy with their own programmable threshold, so software or a DMA engine can refill the queue before it runs dry. If the queue is empty when a sample is needed, the serializer repeats the previous sample and sets a sticky underrun flag.

Top module: `i2s_tx_chan`

## Requirements
- R1: After `rst_n` is asserted the queue level is 0, `ser_ws` is 1, `ser_data` is 0, `underrun` is 0, and each request equals (level < its depth input).
- R2: The queue holds 8 words. `fifo_level` counts accepted words, and a write to a full queue is dropped without changing the level.
- R3: Once running, the first bit-clock tick drives `ser_ws` low. After that it toggles every `cfg_half`+1 ticks; low is the left channel and high is the right channel.
- R4: Each channel sample is sent MSB first, with its first bit on the tick after the word-select change. Positions past the sample width are sent as 0, and bits that do not fit in the phase are dropped.
- R5: `cfg_width` 00 selects 8-bit samples (left = word[7:0], right = word[15:8]). 01 selects 16-bit samples (left = word[15:0], right = word[31:16]). 10 behaves as 01. In stereo, one word carries one frame.
- R6: With `cfg_mono` = 1, each frame uses one word. The low sample-width bits (the whole word at width 11) are sent on both channels.
- R7: With `cfg_width` 11 in stereo, a frame uses two words. The first word is taken at the start of the left phase, and the second at the start of the right phase.
- R8: While `cfg_stop` is 1, writes are ignored, the queue is not read, `ser_ws` stays 1 and `ser_data` stays 0.
- R9: While `cfg_reset` is 1, the queue is emptied, writes are ignored, `underrun` is cleared and the serializer returns to its idle state.
- R10: With `cfg_mute` = 1, `ser_data` is 0. Word select keeps running and queue words are still consumed.
- R11: If the queue is empty when a word is needed, the previous sample of that channel is sent again and `underrun` becomes 1. It stays 1 until `cfg_reset` or `rst_n`.
- R12: `irq_req`, `dma_a_req` and `dma_b_req` are each 1 exactly while `fifo_level` is below `irq_depth`, `dma_a_depth` and `dma_b_depth` respectively.
- R13: A write that arrives in the same cycle as a frame-start read of a full queue is accepted, and the level stays 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle bit-clock enable |
| wr_en | input | 1 | Queue write strobe |
| wr_word | input | 32 | Word to queue |
| cfg_width | input | 2 | Sample width select |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_stop | input | 1 | Halt channel and block queue access |
| cfg_reset | input | 1 | Clear queue and channel state |
| cfg_mute | input | 1 | Force serial data to zero |
| cfg_half | input | 5 | Word-select phase length minus one, in ticks |
| irq_depth | input | 4 | Interrupt request threshold |
| dma_a_depth | input | 4 | First DMA request threshold |
| dma_b_depth | input | 4 | Second DMA request threshold |
| ser_data | output | 1 | Serial audio data |
| ser_ws | output | 1 | Word select |
| fifo_level | output | 4 | Queue occupancy |
| irq_req | output | 1 | Interrupt request |
| dma_a_req | output | 1 | First DMA request |
| dma_b_req | output | 1 | Second DMA request |
| underrun | output | 1 | Sticky empty-queue flag |

## Verification
A queue write and a serializer read can fall on the same clock edge. This matters most when the queue is full, because the write must then be admitted using the slot the read frees. The bench fills the queue to eight words and then asserts the write strobe together with the bit-clock tick that opens each of the next three frames. It judges the result in two ways: the level must read 8 after each of those ticks, and the serial stream must later carry the newly written frames in order after the original eight.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   localparam int unsigned WORD_BITS = 32;

   typedef enum logic [1:0] {
      SW_8    = 2'b00,
      SW_16   = 2'b01,
      SW_RSVD = 2'b10,
      SW_32   = 2'b11
   } smp_width_e;

   // The reserved code falls back to 16-bit samples.
   function automatic smp_width_e eff_width(input logic [1:0] raw);
      if (raw == 2'b10) return SW_16;
      return smp_width_e'(raw);
   endfunction

   // Move a right-aligned sample to the top of the word for MSB-first shifting.
   function automatic logic [WORD_BITS-1:0] left_justify(input logic [WORD_BITS-1:0] s,
                                                         input smp_width_e w);
      case (w)
         SW_8:    return {s[7:0], 24'd0};
         SW_32:   return s;
         default: return {s[15:0], 16'd0};
      endcase
   endfunction

endpackage

// File: rtl/tx_word_fifo.sv
module tx_word_fifo
   import i2s_tx_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned LVL_W = 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 push,
   input  logic [WORD_BITS-1:0] din,
   input  logic                 pop,
   output logic [WORD_BITS-1:0] head,
   output logic [LVL_W-1:0]     level,
   output logic                 empty
);

   localparam int unsigned AW = $clog2(DEPTH);

   logic [WORD_BITS-1:0] mem [DEPTH];
   logic [AW-1:0]        rd_ptr, wr_ptr;
   logic                 full, do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
      end
   end

   p_level_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (level == LVL_W'(DEPTH)));

   p_pushpop_full_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop && !clr) |=> (level == LVL_W'(DEPTH)));

endmodule

// File: rtl/tx_frame_unpack.sv
module tx_frame_unpack
   import i2s_tx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [1:0]           width_raw,
   input  logic                 mono,
   input  logic [WORD_BITS-1:0] head,
   input  logic                 empty,
   input  logic                 start_left,
   input  logic                 start_right,
   output logic                 pop,
   output logic [WORD_BITS-1:0] load_val,
   output logic                 underrun
);

   smp_width_e           w;
   logic                 pair_mode, need_word;
   logic [WORD_BITS-1:0] lo_field, hi_field, left_dec, right_dec;
   logic [WORD_BITS-1:0] left_h, right_h;

   assign w         = eff_width(width_raw);
   assign pair_mode = (w == SW_32) && !mono;
   assign need_word = start_left || (start_right && pair_mode);
   assign pop       = need_word && !empty;

   always_comb begin
      case (w)
         SW_8: begin
            lo_field = {24'd0, head[7:0]};
            hi_field = {24'd0, head[15:8]};
         end
         SW_32: begin
            lo_field = head;
            hi_field = head;
         end
         default: begin
            lo_field = {16'd0, head[15:0]};
            hi_field = {16'd0, head[31:16]};
         end
      endcase
   end

   assign left_dec  = left_justify(lo_field, w);
   assign right_dec = mono ? left_dec : left_justify(hi_field, w);

   always_comb begin
      if (start_left)     load_val = empty ? left_h : left_dec;
      else if (pair_mode) load_val = empty ? right_h : head;
      else                load_val = right_h;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_h   <= '0;
         right_h  <= '0;
         underrun <= 1'b0;
      end else if (clr) begin
         left_h   <= '0;
         right_h  <= '0;
         underrun <= 1'b0;
      end else begin
         if (need_word && empty) underrun <= 1'b1;
         if (start_left && !empty) begin
            left_h <= left_dec;
            if (!pair_mode) right_h <= right_dec;
         end
         if (start_right && pair_mode && !empty) right_h <= head;
      end
   end

   p_urun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_left && empty && !clr) |=> underrun);

   p_urun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !clr) |=> underrun);

endmodule

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter
   import i2s_tx_pkg::*;
#(
   parameter int unsigned HALF_W = 5
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idle,
   input  logic                 tick,
   input  logic [HALF_W-1:0]    half,
   input  logic                 mute,
   input  logic [WORD_BITS-1:0] load_val,
   output logic                 ws,
   output logic                 sd,
   output logic                 start_left,
   output logic                 start_right
);

   logic [HALF_W-1:0]    cnt;
   logic [WORD_BITS-1:0] shreg;
   logic                 wrap;

   // The counter idles at all ones, so the first tick always opens a left phase.
   assign wrap        = (cnt >= half);
   assign start_left  = tick && !idle && wrap && ws;
   assign start_right = tick && !idle && wrap && !ws;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws    <= 1'b1;
         cnt   <= '1;
         shreg <= '0;
         sd    <= 1'b0;
      end else if (idle) begin
         ws    <= 1'b1;
         cnt   <= '1;
         shreg <= '0;
         sd    <= 1'b0;
      end else if (tick) begin
         sd <= shreg[WORD_BITS-1] & ~mute;
         if (wrap) begin
            cnt   <= '0;
            ws    <= ~ws;
            shreg <= load_val;
         end else begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[WORD_BITS-2:0], 1'b0};
         end
      end
   end

   p_ws_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !idle) |=> $stable(ws));

   p_idle_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (ws && !sd));

   p_mute_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mute && tick && !idle) |=> !sd);

endmodule

// File: rtl/tx_level_req.sv
module tx_level_req #(
   parameter int unsigned LVL_W = 4,
   parameter int unsigned NREQ  = 3
)(
   input  logic [LVL_W-1:0]      level,
   input  logic [NREQ*LVL_W-1:0] depths,
   output logic [NREQ-1:0]       req
);

   for (genvar i = 0; i < NREQ; i++) begin : g_cmp
      assign req[i] = (level < depths[i*LVL_W +: LVL_W]);
   end

endmodule

// File: rtl/i2s_tx_chan.sv
module i2s_tx_chan
   import i2s_tx_pkg::*;
#(
   parameter  int unsigned WORD_W = 32,
   parameter  int unsigned DEPTH  = 8,
   parameter  int unsigned HALF_W = 5,
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_tick,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_mono,
   input  logic              cfg_stop,
   input  logic              cfg_reset,
   input  logic              cfg_mute,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic [LVL_W-1:0]  irq_depth,
   input  logic [LVL_W-1:0]  dma_a_depth,
   input  logic [LVL_W-1:0]  dma_b_depth,
   output logic              ser_data,
   output logic              ser_ws,
   output logic [LVL_W-1:0]  fifo_level,
   output logic              irq_req,
   output logic              dma_a_req,
   output logic              dma_b_req,
   output logic              underrun
);

   localparam int unsigned NREQ = 3;

   if (WORD_W != WORD_BITS) begin : g_bad_word
      $error("WORD_W must equal the packed word size");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (HALF_W < 1 || HALF_W > 8) begin : g_bad_half
      $error("HALF_W out of range");
   end

   logic                 idle, push, pop, empty;
   logic                 start_left, start_right;
   logic [WORD_BITS-1:0] head, load_val;
   logic [NREQ-1:0]      req;

   assign idle = cfg_stop | cfg_reset;
   assign push = wr_en & ~idle;

   tx_word_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cfg_reset),
      .push  (push),
      .din   (wr_word),
      .pop   (pop),
      .head  (head),
      .level (fifo_level),
      .empty (empty)
   );

   tx_frame_unpack u_unpack (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (cfg_reset),
      .width_raw   (cfg_width),
      .mono        (cfg_mono),
      .head        (head),
      .empty       (empty),
      .start_left  (start_left),
      .start_right (start_right),
      .pop         (pop),
      .load_val    (load_val),
      .underrun    (underrun)
   );

   tx_bit_shifter #(.HALF_W(HALF_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle        (idle),
      .tick        (bclk_tick),
      .half        (cfg_half),
      .mute        (cfg_mute),
      .load_val    (load_val),
      .ws          (ser_ws),
      .sd          (ser_data),
      .start_left  (start_left),
      .start_right (start_right)
   );

   tx_level_req #(.LVL_W(LVL_W), .NREQ(NREQ)) u_req (
      .level  (fifo_level),
      .depths ({dma_b_depth, dma_a_depth, irq_depth}),
      .req    (req)
   );

   assign irq_req   = req[0];
   assign dma_a_req = req[1];
   assign dma_b_req = req[2];

   p_req_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == '0 && irq_depth != '0) |-> irq_req);

   p_stop_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stop && !cfg_reset) |=> $stable(fifo_level));

endmodule

// File: tb/i2s_tx_chan_test.sv
module i2s_tx_chan_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_tick = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_word = '0;
   logic [1:0]  cfg_width = 2'b01;
   logic        cfg_mono = 1'b0, cfg_stop = 1'b1, cfg_reset = 1'b0, cfg_mute = 1'b0;
   logic [4:0]  cfg_half = 5'd15;
   logic [3:0]  irq_depth = 4'd2, dma_a_depth = 4'd0, dma_b_depth = 4'd8;
   logic        ser_data, ser_ws, irq_req, dma_a_req, dma_b_req, underrun;
   logic [3:0]  fifo_level;

   int    n_chk = 0, n_bad = 0, tcount = 0, hlen = 16;
   bit    mute_f = 0, done = 0;
   string cur_tag = "R4";
   logic  exp_q[$];
   event  tick_ev;

   always #2 clk = ~clk;

   i2s_tx_chan uut (
      .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .wr_en(wr_en), .wr_word(wr_word),
      .cfg_width(cfg_width), .cfg_mono(cfg_mono), .cfg_stop(cfg_stop), .cfg_reset(cfg_reset),
      .cfg_mute(cfg_mute), .cfg_half(cfg_half), .irq_depth(irq_depth),
      .dma_a_depth(dma_a_depth), .dma_b_depth(dma_b_depth), .ser_data(ser_data),
      .ser_ws(ser_ws), .fifo_level(fifo_level), .irq_req(irq_req), .dma_a_req(dma_a_req),
      .dma_b_req(dma_b_req), .underrun(underrun)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   // Monitor: compares word select and serial data after every bit tick.
   always @(tick_ev) begin
      logic e_ws, e_sd;
      e_ws = (((tcount - 1) / hlen) % 2) == 1;
      chk(ser_ws == e_ws, "R3 word select", ser_ws, e_ws);
      if (tcount == 1) e_sd = 1'b0;
      else if (exp_q.size() == 0) begin
         e_sd = 1'b0;
         chk(1'b0, {"R4 ", cur_tag, " scoreboard empty"}, 0, 1);
      end else e_sd = exp_q.pop_front();
      chk(ser_data == e_sd, {"R4 ", cur_tag, " serial bit"}, ser_data, e_sd);
   end

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] w);
      wr_en = 1'b1;
      wr_word = w;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic tick(input bit push, input logic [31:0] w);
      bclk_tick = 1'b1;
      wr_en = push;
      wr_word = w;
      cyc();
      bclk_tick = 1'b0;
      wr_en = 1'b0;
      tcount++;
      ->tick_ev;
      cyc();
   endtask

   function automatic logic [31:0] gen(input int n);
      return (32'h9E37_79B9 * (n + 3)) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic int wbits(input logic [1:0] c);
      case (c)
         2'b00:   return 8;
         2'b11:   return 32;
         default: return 16;
      endcase
   endfunction

   task automatic enq_half(input logic [31:0] s, input int w);
      for (int i = 0; i < hlen; i++)
         exp_q.push_back(mute_f ? 1'b0 : ((i < w) ? s[w-1-i] : 1'b0));
   endtask

   task automatic restart(input logic [1:0] wid, input bit mono, input int half, input bit mute);
      cfg_stop = 1'b1;
      cfg_reset = 1'b1;
      cyc();
      cfg_reset = 1'b0;
      cfg_width = wid;
      cfg_mono = mono;
      cfg_half = 5'(half);
      cfg_mute = mute;
      cyc();
      cfg_stop = 1'b0;
      cyc();
      tcount = 0;
      hlen = half + 1;
      mute_f = mute;
      exp_q.delete();
   endtask

   task automatic run_case(input string tag, input logic [1:0] wid, input bit mono,
                           input int half, input bit mute, input int frames, input int extra);
      int w, nw;
      bit pair;
      logic [31:0] l, r, word, mask;
      w = wbits(wid);
      pair = (wid == 2'b11) && !mono;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      nw = 0;
      l = '0;
      r = '0;
      restart(wid, mono, half, mute);
      cur_tag = tag;
      for (int f = 0; f < frames; f++) begin
         word = gen(f * 2 + half);
         wr(word);
         nw++;
         if (pair) begin
            l = word;
            word = gen(f * 2 + half + 1);
            wr(word);
            nw++;
            r = word;
         end else if (mono) begin
            l = word & mask;
            r = l;
         end else begin
            l = word & mask;
            r = (word >> w) & mask;
         end
         enq_half(l, w);
         enq_half(r, w);
      end
      chk(fifo_level == 4'(nw), {"R2 ", tag, " level after writes"}, fifo_level, nw);
      for (int e = 0; e < extra; e++) begin
         enq_half(l, w);
         enq_half(r, w);
      end
      for (int t = 0; t < 1 + (frames + extra) * 2 * hlen; t++) tick(1'b0, '0);
      chk(exp_q.size() == 0, {"R4 ", tag, " all bits sent"}, exp_q.size(), 0);
      chk(fifo_level == 0, {"R10 ", tag, " queue drained"}, fifo_level, 0);
      chk(underrun == 1'b1, {"R11 ", tag, " underrun after drain"}, underrun, 1);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int pushed;
      logic [31:0] nw_word;
      // R1: reset state
      cyc();
      rst_n = 1'b1;
      cyc();
      chk(fifo_level == 0, "R1 level", fifo_level, 0);
      chk(ser_ws == 1'b1, "R1 ws idle", ser_ws, 1);
      chk(ser_data == 1'b0, "R1 data idle", ser_data, 0);
      chk(underrun == 1'b0, "R1 underrun", underrun, 0);
      chk({irq_req, dma_a_req, dma_b_req} == 3'b101, "R1 requests", {irq_req, dma_a_req, dma_b_req}, 3'b101);

      // R2, R12, R8, R9: level, thresholds, stop and clear
      restart(2'b01, 1'b0, 15, 1'b0);
      irq_depth = 4'd4;
      dma_a_depth = 4'd3;
      dma_b_depth = 4'd2;
      for (int i = 0; i < 3; i++) wr(gen(i));
      chk(fifo_level == 3, "R2 level three", fifo_level, 3);
      chk({irq_req, dma_a_req, dma_b_req} == 3'b100, "R12 level three", {irq_req, dma_a_req, dma_b_req}, 3'b100);
      wr(gen(3));
      chk(irq_req == 1'b0, "R12 irq at depth", irq_req, 0);
      cfg_stop = 1'b1;
      cyc();
      wr(gen(9));
      chk(fifo_level == 4, "R8 write ignored", fifo_level, 4);
      for (int i = 0; i < 40; i++) begin
         bclk_tick = 1'b1;
         cyc();
         bclk_tick = 1'b0;
         cyc();
         if (ser_ws != 1'b1 || ser_data != 1'b0)
            chk(1'b0, "R8 outputs held", {ser_ws, ser_data}, 2'b10);
      end
      chk(fifo_level == 4, "R8 no read while stopped", fifo_level, 4);
      cfg_stop = 1'b0;
      cyc();
      for (int i = 0; i < 5; i++) wr(gen(10 + i));
      chk(fifo_level == 8, "R2 full write dropped", fifo_level, 8);
      chk({irq_req, dma_a_req, dma_b_req} == 3'b000, "R12 full", {irq_req, dma_a_req, dma_b_req}, 3'b000);
      cfg_reset = 1'b1;
      cyc();
      wr(gen(20));
      chk(fifo_level == 0, "R9 cleared", fifo_level, 0);
      chk({irq_req, dma_a_req, dma_b_req} == 3'b111, "R12 empty", {irq_req, dma_a_req, dma_b_req}, 3'b111);
      cfg_reset = 1'b0;
      cyc();

      // Serial formats
      run_case("R5", 2'b01, 1'b0, 15, 1'b0, 3, 1);
      run_case("R5", 2'b00, 1'b0, 9, 1'b0, 2, 0);
      run_case("R5", 2'b10, 1'b0, 11, 1'b0, 1, 0);
      run_case("R7", 2'b11, 1'b0, 31, 1'b0, 2, 1);
      run_case("R6", 2'b01, 1'b1, 15, 1'b0, 3, 0);
      run_case("R6", 2'b11, 1'b1, 19, 1'b0, 2, 0);
      run_case("R10", 2'b01, 1'b0, 15, 1'b1, 2, 0);
      run_case("R11", 2'b00, 1'b0, 7, 1'b0, 1, 2);

      // R9: clear drops the sticky flag
      cfg_reset = 1'b1;
      cyc();
      chk(underrun == 1'b0, "R9 underrun cleared", underrun, 0);
      chk(ser_ws == 1'b1, "R9 ws idle", ser_ws, 1);
      cfg_reset = 1'b0;
      cyc();

      // R13: write together with a frame-start read of a full queue
      restart(2'b01, 1'b0, 7, 1'b0);
      cur_tag = "R13";
      for (int i = 0; i < 8; i++) begin
         nw_word = gen(100 + i);
         wr(nw_word);
         enq_half({16'd0, nw_word[15:0]}, 16);
         enq_half({16'd0, nw_word[31:16]}, 16);
      end
      chk(fifo_level == 8, "R13 filled", fifo_level, 8);
      pushed = 0;
      for (int t = 0; t < 1 + 11 * 2 * hlen; t++) begin
         if ((tcount % (2 * hlen)) == 0 && pushed < 3) begin
            nw_word = gen(200 + pushed);
            enq_half({16'd0, nw_word[15:0]}, 16);
            enq_half({16'd0, nw_word[31:16]}, 16);
            tick(1'b1, nw_word);
            pushed++;
            chk(fifo_level == 8, "R13 level stays full", fifo_level, 8);
         end else tick(1'b0, '0);
      end
      chk(exp_q.size() == 0, "R13 all frames sent", exp_q.size(), 0);

      done = 1;
      summary();
      $finish;
   end

endmodule